// File: doc/BRIEF.md
# Windowed Zero-Crossing Mute Gate

This block sits in a stereo sample path and silences or restores each channel without an audible click. A mute request does not act at once: each channel keeps its present state until one of its own samples falls inside a symmetric window around zero. Only then does that channel switch. Because the left and right channels look for their window entry separately, one side may go quiet some samples before the other.

The window width is chosen at run time from four sizes. Their thresholds are parameters given in sample codes, and each size is half of the next wider one. A detector-off input stops the comparison completely. While it is set, both channels pass their samples straight through. A status output shows whether the mute is fully in effect. The control bits are plain inputs, and the block expects the surrounding logic to hold them at steady levels.

Top module: `zc_mute_gate`

## Requirements
- R1: While reset is active and after it is released, out_valid, out_left, out_right and zc_muted are 0, both channels are unmuted and no change is pending.
- R2: When a channel's target mute state differs from its current state, a valid sample outside the selected window leaves the state unchanged, and the sample goes to the output according to the old state.
- R3: The first valid sample inside the window switches a pending channel to muted. That sample and every later sample on that channel come out as 0.
- R4: The left and right channels test their own samples against the window. One channel can switch on a given sample while the other keeps its state.
- R5: win_sel 0, 1, 2 and 3 select the thresholds 1120, 560, 280 and 140 codes by default. A sample x is inside the window when -T <= x <= T, so T is inside and T+1 is outside.
- R6: Unmuting works in the same way. A muted channel keeps giving 0 until one of its samples falls inside the window. That sample then passes unchanged.
- R7: If mute_req returns to the channel's current state before a sample has applied the change, the pending change is dropped and the channel keeps its state.
- R8: While det_off is 1, both channels are unmuted, samples pass unchanged, zc_muted is 0 and mute_req has no effect. After det_off clears, a mute request waits for a window entry again.
- R9: zc_muted is 1 only when both channels are in the muted state.
- R10: A sample presented with in_valid at one clock edge appears on out_left and out_right, with out_valid set, after that edge. Cycles without in_valid do not change any channel state.
- R11: The most negative code, -32768, lies outside every window and never triggers a switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The sample pair on in_left and in_right is present |
| in_left | input | 16 | Left sample, signed two's complement |
| in_right | input | 16 | Right sample, signed two's complement |
| mute_req | input | 1 | Requested mute state, 1 = mute |
| win_sel | input | 2 | Window size, 0 = widest, 3 = narrowest |
| det_off | input | 1 | Stops the detector and forces pass-through |
| out_valid | output | 1 | Registered copy of in_valid |
| out_left | output | 16 | Gated left sample |
| out_right | output | 16 | Gated right sample |
| zc_muted | output | 1 | Both channels are muted |

## Verification
The hardest state to reach from the ports is a pending change that stays pending. To hold it there, the stimulus must keep feeding samples that lie just outside the window on one channel while the other channel switches, and then reverse the request before any qualifying sample arrives. The directed tasks do this with samples placed at threshold and threshold plus one for every window size, and they check that the outputs show the old state. The same approach covers the cases where det_off clears a muted state and where -32768 is rejected as outside the window.

// File: rtl/zcm_pkg.sv
package zcm_pkg;
   localparam int NUM_CH = 2;
   localparam int CH_L   = 0;
   localparam int CH_R   = 1;

   typedef enum logic [1:0] {
      WIN_WIDE   = 2'd0,
      WIN_MID    = 2'd1,
      WIN_SMALL  = 2'd2,
      WIN_TIGHT  = 2'd3
   } win_sel_e;
endpackage

// File: rtl/zcm_window_cmp.sv
module zcm_window_cmp
   import zcm_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int THR_W0    = 1120,
   parameter int THR_W1    = 560,
   parameter int THR_W2    = 280,
   parameter int THR_W3    = 140,
   parameter bit INCLUSIVE = 1'b1
) (
   input  logic [DATA_W-1:0] smp,
   input  logic [1:0]        sel,
   output logic              hit
);
   localparam int EXT_W = DATA_W + 1;
   localparam logic signed [EXT_W-1:0] T0 = EXT_W'(THR_W0);
   localparam logic signed [EXT_W-1:0] T1 = EXT_W'(THR_W1);
   localparam logic signed [EXT_W-1:0] T2 = EXT_W'(THR_W2);
   localparam logic signed [EXT_W-1:0] T3 = EXT_W'(THR_W3);

   logic signed [EXT_W-1:0] s_ext;
   logic signed [EXT_W-1:0] thr;
   logic signed [EXT_W-1:0] thr_neg;

   always_comb begin
      s_ext = $signed({smp[DATA_W-1], smp});
      unique case (win_sel_e'(sel))
         WIN_WIDE:  thr = T0;
         WIN_MID:   thr = T1;
         WIN_SMALL: thr = T2;
         default:   thr = T3;
      endcase
      thr_neg = -thr;
   end

   generate
      if (INCLUSIVE) begin : g_incl
         assign hit = (s_ext <= thr) && (s_ext >= thr_neg);
      end else begin : g_excl
         assign hit = (s_ext < thr) && (s_ext > thr_neg);
      end
   endgenerate
endmodule

// File: rtl/zcm_channel.sv
module zcm_channel #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp,
   input  logic              win_hit,
   input  logic              mute_req,
   input  logic              det_off,
   output logic [DATA_W-1:0] out_smp,
   output logic              muted
);
   logic apply;
   logic nxt_muted;

   always_comb begin
      apply     = smp_valid && !det_off && win_hit;
      nxt_muted = det_off ? 1'b0 : (apply ? mute_req : muted);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         muted   <= 1'b0;
         out_smp <= '0;
      end else begin
         muted <= nxt_muted;
         if (smp_valid) begin
            out_smp <= nxt_muted ? '0 : smp;
         end
      end
   end
endmodule

// File: rtl/zc_mute_gate.sv
module zc_mute_gate
   import zcm_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int THR_W0    = 1120,
   parameter int THR_W1    = 560,
   parameter int THR_W2    = 280,
   parameter int THR_W3    = 140,
   parameter bit INCLUSIVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_left,
   input  logic [DATA_W-1:0] in_right,
   input  logic              mute_req,
   input  logic [1:0]        win_sel,
   input  logic              det_off,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_left,
   output logic [DATA_W-1:0] out_right,
   output logic              zc_muted
);
   localparam longint MAX_POS = (64'sd1 <<< (DATA_W - 1)) - 1;

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("zc_mute_gate: DATA_W must be at least 2");
      end
      if (!(THR_W0 > THR_W1 && THR_W1 > THR_W2 && THR_W2 > THR_W3 && THR_W3 > 0)) begin : g_bad_order
         $error("zc_mute_gate: thresholds must be positive and strictly narrowing");
      end
      if (longint'(THR_W0) > MAX_POS) begin : g_bad_range
         $error("zc_mute_gate: widest threshold exceeds sample range");
      end
   endgenerate

   logic [DATA_W-1:0] smp_in  [NUM_CH];
   logic [DATA_W-1:0] smp_out [NUM_CH];
   logic [NUM_CH-1:0] win_hit;
   logic [NUM_CH-1:0] mute_st;

   assign smp_in[CH_L] = in_left;
   assign smp_in[CH_R] = in_right;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      zcm_window_cmp #(
         .DATA_W   (DATA_W),
         .THR_W0   (THR_W0),
         .THR_W1   (THR_W1),
         .THR_W2   (THR_W2),
         .THR_W3   (THR_W3),
         .INCLUSIVE(INCLUSIVE)
      ) u_cmp (
         .smp (smp_in[c]),
         .sel (win_sel),
         .hit (win_hit[c])
      );

      zcm_channel #(
         .DATA_W(DATA_W)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .smp_valid(in_valid),
         .smp      (smp_in[c]),
         .win_hit  (win_hit[c]),
         .mute_req (mute_req),
         .det_off  (det_off),
         .out_smp  (smp_out[c]),
         .muted    (mute_st[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
      end
   end

   assign out_left  = smp_out[CH_L];
   assign out_right = smp_out[CH_R];
   assign zc_muted  = &mute_st;
endmodule

// File: rtl/zcm_checker.sv
module zcm_checker #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_left,
   input logic [DATA_W-1:0] in_right,
   input logic              mute_req,
   input logic              det_off,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_left,
   input logic [DATA_W-1:0] out_right,
   input logic              zc_muted,
   input logic [1:0]        mute_st,
   input logic [1:0]        win_hit
);
   a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r10_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !det_off) |=> $stable(mute_st));

   a_r2_outside_holds_l: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !det_off && !win_hit[0]) |=> $stable(mute_st[0]));

   a_r2_outside_holds_r: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !det_off && !win_hit[1]) |=> $stable(mute_st[1]));

   a_r3_left_applies: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !det_off && win_hit[0]) |=> (mute_st[0] == $past(mute_req)));

   a_r4_right_applies: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !det_off && win_hit[1]) |=> (mute_st[1] == $past(mute_req)));

   a_r8_off_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && det_off) |=> (out_left == $past(in_left) &&
                                 out_right == $past(in_right) && !zc_muted));

   a_r9_status_means_silent: assert property (@(posedge clk) disable iff (!rst_n)
      zc_muted |-> (out_left == '0 && out_right == '0));
endmodule

bind zc_mute_gate zcm_checker #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_left  (in_left),
   .in_right (in_right),
   .mute_req (mute_req),
   .det_off  (det_off),
   .out_valid(out_valid),
   .out_left (out_left),
   .out_right(out_right),
   .zc_muted (zc_muted),
   .mute_st  (mute_st),
   .win_hit  (win_hit)
);

// File: tb/sim_zc_mute_gate.sv
module sim_zc_mute_gate;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [15:0] in_left;
   logic [15:0] in_right;
   logic        mute_req;
   logic [1:0]  win_sel;
   logic        det_off;
   logic        out_valid;
   logic [15:0] out_left;
   logic [15:0] out_right;
   logic        zc_muted;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   zc_mute_gate u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_left  (in_left),
      .in_right (in_right),
      .mute_req (mute_req),
      .win_sel  (win_sel),
      .det_off  (det_off),
      .out_valid(out_valid),
      .out_left (out_left),
      .out_right(out_right),
      .zc_muted (zc_muted)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic push(input int l, input int r);
      @(negedge clk);
      in_valid = 1'b1;
      in_left  = 16'(l);
      in_right = 16'(r);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic expect_out(input string tag, input int l, input int r, input int st);
      chk({tag, " left"},  int'($signed(out_left)),  l);
      chk({tag, " right"}, int'($signed(out_right)), r);
      chk({tag, " status"}, int'(zc_muted), st);
   endtask

   task automatic t_reset;
      chk("R1 out_valid in reset", int'(out_valid), 0);
      expect_out("R1 reset", 0, 0, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 out_valid after reset", int'(out_valid), 0);
      expect_out("R1 after reset", 0, 0, 0);
   endtask

   task automatic t_latency;
      push(1000, -2000);
      chk("R10 out_valid", int'(out_valid), 1);
      expect_out("R10 pass", 1000, -2000, 0);
      @(negedge clk);
      chk("R10 out_valid drops", int'(out_valid), 0);
   endtask

   task automatic t_outside_then_enter;
      win_sel  = 2'd0;
      mute_req = 1'b1;
      push(5000, -5000);
      expect_out("R2 outside keeps", 5000, -5000, 0);
      push(100, -6000);
      expect_out("R3 R4 left enters", 0, -6000, 0);
      push(300, 7000);
      expect_out("R3 left stays muted", 0, 7000, 0);
      push(2000, -50);
      expect_out("R9 both muted", 0, 0, 1);
      push(5000, 5000);
      expect_out("R3 muted holds", 0, 0, 1);
   endtask

   task automatic t_unmute;
      mute_req = 1'b0;
      push(4000, 30);
      expect_out("R6 R9 right leaves", 0, 30, 0);
      push(10, 4000);
      expect_out("R6 left leaves", 10, 4000, 0);
   endtask

   task automatic t_windows;
      for (int s = 0; s < 4; s++) begin
         int thr = 1120 >> s;
         win_sel  = 2'(s);
         mute_req = 1'b1;
         push(thr + 1, thr);
         expect_out($sformatf("R5 sel%0d edge", s), thr + 1, 0, 0);
         push(-thr, 9000);
         expect_out($sformatf("R5 sel%0d neg edge", s), 0, 0, 1);
         mute_req = 1'b0;
         push(-thr, -thr - 1);
         expect_out($sformatf("R5 sel%0d unmute edge", s), -thr, 0, 0);
         push(0, 0);
         push(77, -77);
         expect_out($sformatf("R5 sel%0d clear", s), 77, -77, 0);
      end
   endtask

   task automatic t_cancel;
      win_sel  = 2'd0;
      mute_req = 1'b1;
      push(5000, 5000);
      expect_out("R7 pending", 5000, 5000, 0);
      mute_req = 1'b0;
      push(5, -5);
      expect_out("R7 cancelled", 5, -5, 0);
   endtask

   task automatic t_disable;
      mute_req = 1'b1;
      push(0, 0);
      chk("R8 setup status", int'(zc_muted), 1);
      det_off = 1'b1;
      push(20, 30);
      expect_out("R8 off passes", 20, 30, 0);
      push(3, -3);
      expect_out("R8 req ignored", 3, -3, 0);
      det_off = 1'b0;
      push(9000, 9000);
      expect_out("R8 re-armed waits", 9000, 9000, 0);
      push(1, 1);
      expect_out("R8 re-armed applies", 0, 0, 1);
      mute_req = 1'b0;
      push(0, 0);
      push(12, 13);
      expect_out("R8 restore", 12, 13, 0);
   endtask

   task automatic t_extreme;
      win_sel  = 2'd0;
      mute_req = 1'b1;
      push(-32768, 32767);
      expect_out("R11 extremes outside", -32768, 32767, 0);
      mute_req = 1'b0;
   endtask

   task automatic t_idle;
      mute_req = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      in_left  = 16'd0;
      in_right = 16'd0;
      repeat (3) @(negedge clk);
      push(6000, 6000);
      expect_out("R10 idle cycles ignored", 6000, 6000, 0);
      mute_req = 1'b0;
   endtask

   initial begin
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_left  = '0;
      in_right = '0;
      mute_req = 1'b0;
      win_sel  = 2'd0;
      det_off  = 1'b0;
      repeat (3) @(negedge clk);
      t_reset;
      t_latency;
      t_outside_then_enter;
      t_unmute;
      t_windows;
      t_cancel;
      t_disable;
      t_extreme;
      t_idle;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule